// File: doc/BRIEF.md
# Ring Bus Byte FIFO Peripheral

This block is one station on an 8-bit serpentine peripheral bus. Data enters on `dat_i` and leaves on `dat_o`, and the bus controller visits each station in turn. When a station is not strobed it passes the ring byte through untouched, so the ring stays intact whatever mix of stations is fitted. When strobed, the station either serves a register access (tag high) or answers a poll (tag low, read) with the number of bytes it has waiting for the host.

Inside the block sit a small bank of plain byte registers at the lowest addresses and one address that acts as the head of a byte FIFO. A bus write to that address pushes a byte, and a bus read pops one. Acknowledge doubles as the FIFO flow signal: a push into a full FIFO or a pop from an empty one completes without acknowledge, so the controller can count how many bytes got through. The FIFO memory output is registered, so every FIFO read stalls for one cycle before it completes. A field-side stimulus port also feeds bytes into the FIFO. This models the data that the peripheral collects on its own. The poll answer is the FIFO occupancy.

Top module: `ringbus_fifo_periph`

## Requirements
- R1: While `stb_i` is low, `dat_o` equals `dat_i` in the same cycle, and `ack_o` and `stall_o` are low.
- R2: With `stb_i`, `tag_i` high and `adr_i` below `NREG` (default 4), a write stores `dat_i` in register `adr_i` at the clock edge, and a read drives that register on `dat_o` whatever `dat_i` is. Both acknowledge in the same cycle, without stall. Registers reset to 0.
- R3: A poll (`stb_i` high, `tag_i` low, `we_i` low) drives on `dat_o` the FIFO occupancy, saturated at 255. It acknowledges in the same cycle, without stall.
- R4: A write with `tag_i` high to `FIFO_ADDR` (default 0x10) is acknowledged in the same cycle and pushes `dat_i` exactly when the FIFO holds fewer than `DEPTH` (default 16) bytes. A push into a full FIFO gets no acknowledge and leaves the FIFO unchanged.
- R5: A read with `tag_i` high from `FIFO_ADDR` holds `stall_o` high for exactly the first strobed cycle, with `ack_o` low. In the following cycle `stall_o` is low. If the FIFO was non-empty in the stall cycle, `ack_o` is high and `dat_o` carries the oldest byte, which is removed at that edge. Bytes leave in the order they entered.
- R6: A FIFO read that finds the FIFO empty in its stall cycle completes without acknowledge, and during completion `dat_o` equals `dat_i`.
- R7: A strobed access to any other address, and a write with `tag_i` low, is neither acknowledged nor stalled. `dat_o` equals `dat_i`, and no register or FIFO content changes.
- R8: A cycle with `src_push` high appends `src_byte` to the FIFO unless the FIFO is full or a bus write to `FIFO_ADDR` is strobed in the same cycle. In either of those cases the byte is dropped. A pop in the same cycle does not make room for the byte.
- R9: After reset the FIFO is empty, so a poll returns 0 and a FIFO read is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stb_i | input | 1 | Station selected for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| tag_i | input | 1 | 1 = register access, 0 = poll |
| adr_i | input | 8 | Register address within the station |
| dat_i | input | 8 | Ring data arriving at the station |
| src_push | input | 1 | Field-side byte is offered |
| src_byte | input | 8 | Field-side byte |
| stall_o | output | 1 | More cycles are needed to complete the access |
| ack_o | output | 1 | Access completed successfully |
| dat_o | output | 8 | Ring data leaving the station |

## Verification
A wrong FIFO pointer or count shows up at the next poll as a wrong occupancy byte, and at the next FIFO read as a wrong byte or a missing acknowledge. Any such fault therefore appears within one bus cycle of the access that next looks at the FIFO. A wrong read phase shows directly as a missing stall or a doubled stall on the following FIFO read. A decode fault shows in the same cycle, as an acknowledge on an unmapped address or as a ring byte altered while the station is idle. Random traffic mixes source pushes with bus accesses in the same cycle, so the priority and full rules are checked against the bench's own queue every cycle.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_REG_WR,
    ACC_REG_RD,
    ACC_FIFO_WR,
    ACC_FIFO_RD,
    ACC_POLL,
    ACC_UNMAPPED
  } acc_kind_t;

  // Occupancy reported on a poll: clamp to one byte.
  function automatic logic [7:0] poll_byte(input int unsigned level);
    if (level > 255) return 8'hFF;
    return level[7:0];
  endfunction

  // True when a register-tagged address hits the plain register bank.
  function automatic logic in_reg_bank(input logic [7:0] adr, input int unsigned nreg);
    return 32'(adr) < nreg;
  endfunction

endpackage

// File: rtl/rbf_decode.sv
module rbf_decode
  import rbf_pkg::*;
#(
  parameter int unsigned NREG      = 4,
  parameter logic [7:0]  FIFO_ADDR = 8'h10,
  localparam int unsigned IW       = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          stb,
  input  logic          we,
  input  logic          tag,
  input  logic [7:0]    adr,
  output acc_kind_t     kind,
  output logic [IW-1:0] reg_idx
);

  always_comb begin
    kind    = ACC_NONE;
    reg_idx = adr[IW-1:0];
    if (stb) begin
      if (!tag) begin
        kind = we ? ACC_UNMAPPED : ACC_POLL;
      end else if (adr == FIFO_ADDR) begin
        kind = we ? ACC_FIFO_WR : ACC_FIFO_RD;
      end else if (in_reg_bank(adr, NREG)) begin
        kind = we ? ACC_REG_WR : ACC_REG_RD;
      end else begin
        kind = ACC_UNMAPPED;
      end
    end
  end

endmodule

// File: rtl/rbf_regfile.sv
module rbf_regfile #(
  parameter int unsigned NREG = 4,
  parameter int unsigned DW   = 8,
  localparam int unsigned IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (wr_en && (idx == IW'(g))) begin
        regs_q[g] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (idx == IW'(i)) rdata = regs_q[i];
    end
  end

endmodule

// File: rtl/rbf_fifo.sv
module rbf_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          capture,
  output logic [DW-1:0] head_q,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;

  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    if (32'(p) == DEPTH - 1) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  // Registered memory output: loaded in the stall cycle of a read.
  always_ff @(posedge clk) begin
    if (!rst_n)       head_q <= '0;
    else if (capture) head_q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/ringbus_fifo_periph.sv
module ringbus_fifo_periph
  import rbf_pkg::*;
#(
  parameter int unsigned NREG      = 4,
  parameter int unsigned DEPTH     = 16,
  parameter logic [7:0]  FIFO_ADDR = 8'h10,
  localparam int unsigned IW       = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb_i,
  input  logic       we_i,
  input  logic       tag_i,
  input  logic [7:0] adr_i,
  input  logic [7:0] dat_i,
  input  logic       src_push,
  input  logic [7:0] src_byte,
  output logic       stall_o,
  output logic       ack_o,
  output logic [7:0] dat_o
);

  acc_kind_t     kind;
  logic [IW-1:0] reg_idx;
  logic [7:0]    reg_rdata;
  logic [7:0]    fifo_head;
  logic [CW-1:0] fifo_count;
  logic          fifo_full, fifo_empty;

  // Named internal events
  logic rd_phase_q;   // 1 in the completion cycle of a FIFO read
  logic rd_ok_q;      // FIFO was non-empty in that read's stall cycle
  logic bus_push, src_accept, fifo_push, fifo_pop, fifo_capture;
  logic [7:0] push_byte;

  rbf_decode #(.NREG(NREG), .FIFO_ADDR(FIFO_ADDR)) u_dec (
    .stb(stb_i), .we(we_i), .tag(tag_i), .adr(adr_i),
    .kind(kind), .reg_idx(reg_idx)
  );

  rbf_regfile #(.NREG(NREG), .DW(8)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(kind == ACC_REG_WR), .idx(reg_idx), .wdata(dat_i),
    .rdata(reg_rdata)
  );

  assign bus_push     = (kind == ACC_FIFO_WR) && !fifo_full;
  assign src_accept   = src_push && !fifo_full && (kind != ACC_FIFO_WR);
  assign fifo_push    = bus_push || src_accept;
  assign push_byte    = bus_push ? dat_i : src_byte;
  assign fifo_capture = (kind == ACC_FIFO_RD) && !rd_phase_q;
  assign fifo_pop     = (kind == ACC_FIFO_RD) && rd_phase_q && rd_ok_q;

  rbf_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(fifo_push), .push_data(push_byte),
    .pop(fifo_pop), .capture(fifo_capture),
    .head_q(fifo_head), .count(fifo_count),
    .full(fifo_full), .empty(fifo_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_phase_q <= 1'b0;
      rd_ok_q    <= 1'b0;
    end else begin
      rd_phase_q <= fifo_capture;
      if (fifo_capture) rd_ok_q <= !fifo_empty;
    end
  end

  always_comb begin
    stall_o = 1'b0;
    ack_o   = 1'b0;
    dat_o   = dat_i;
    unique case (kind)
      ACC_REG_WR:  ack_o = 1'b1;
      ACC_REG_RD: begin
        ack_o = 1'b1;
        dat_o = reg_rdata;
      end
      ACC_FIFO_WR: ack_o = !fifo_full;
      ACC_FIFO_RD: begin
        stall_o = !rd_phase_q;
        ack_o   = rd_phase_q && rd_ok_q;
        if (rd_phase_q && rd_ok_q) dat_o = fifo_head;
      end
      ACC_POLL: begin
        ack_o = 1'b1;
        dat_o = poll_byte(32'(fifo_count));
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rbf_checker.sv
module rbf_checker #(
  parameter int unsigned NREG      = 4,
  parameter int unsigned DEPTH     = 16,
  parameter logic [7:0]  FIFO_ADDR = 8'h10,
  parameter int unsigned CW        = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stb_i,
  input logic          we_i,
  input logic          tag_i,
  input logic [7:0]    adr_i,
  input logic [7:0]    dat_i,
  input logic [7:0]    dat_o,
  input logic          ack_o,
  input logic          stall_o,
  input logic          fifo_full,
  input logic [CW-1:0] fifo_count
);

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |-> (dat_o == dat_i) && !ack_o && !stall_o); // R1

  AST_POLL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && !tag_i && !we_i) |-> ack_o && !stall_o); // R3

  AST_FULL_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && tag_i && we_i && adr_i == FIFO_ADDR && fifo_full) |-> !ack_o); // R4

  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> !stall_o); // R5

  AST_STALL_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> !ack_o); // R5

  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && tag_i && adr_i != FIFO_ADDR && 32'(adr_i) >= NREG)
      |-> !ack_o && !stall_o && (dat_o == dat_i)); // R7

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fifo_count) <= DEPTH); // R8

endmodule

bind ringbus_fifo_periph rbf_checker #(
  .NREG(NREG), .DEPTH(DEPTH), .FIFO_ADDR(FIFO_ADDR), .CW(CW)
) u_rbf_checker (
  .clk(clk), .rst_n(rst_n), .stb_i(stb_i), .we_i(we_i), .tag_i(tag_i),
  .adr_i(adr_i), .dat_i(dat_i), .dat_o(dat_o), .ack_o(ack_o),
  .stall_o(stall_o), .fifo_full(fifo_full), .fifo_count(fifo_count)
);

// File: tb/ringbus_fifo_periph_bench.sv
module ringbus_fifo_periph_bench;

  localparam int unsigned NREG  = 4;
  localparam int unsigned DEPTH = 16;
  localparam logic [7:0]  FADR  = 8'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb_i = 1'b0, we_i = 1'b0, tag_i = 1'b0;
  logic [7:0] adr_i = '0, dat_i = '0, src_byte = '0;
  logic src_push = 1'b0;
  logic stall_o, ack_o;
  logic [7:0] dat_o;

  always #10 clk = ~clk;

  ringbus_fifo_periph #(.NREG(NREG), .DEPTH(DEPTH), .FIFO_ADDR(FADR)) u_ringbus_fifo_periph (
    .clk(clk), .rst_n(rst_n), .stb_i(stb_i), .we_i(we_i), .tag_i(tag_i),
    .adr_i(adr_i), .dat_i(dat_i), .src_push(src_push), .src_byte(src_byte),
    .stall_o(stall_o), .ack_o(ack_o), .dat_o(dat_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] mreg [NREG];
  logic [7:0] q [$];

  function automatic logic [7:0] exp_poll(input int n);
    return (n >= 255) ? 8'd255 : 8'(n);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic s, input logic t, input logic w, input logic [7:0] a,
                       input logic [7:0] d, input logic p, input logic [7:0] pb);
    stb_i = s; tag_i = t; we_i = w; adr_i = a; dat_i = d; src_push = p; src_byte = pb;
  endtask

  // Source push rule, evaluated on the occupancy before the edge.
  task automatic src_apply(input logic p, input logic [7:0] pb, input bit blocked, input int pre);
    if (p && !blocked && pre < DEPTH) q.push_back(pb);
  endtask

  task automatic t_idle(input logic [7:0] d, input logic p, input logic [7:0] pb);
    int pre;
    @(negedge clk); drive(0, $urandom_range(0,1), $urandom_range(0,1), 8'($urandom), d, p, pb);
    #5;
    chk(dat_o == d, "R1 pass-through", dat_o, d);
    chk(!ack_o && !stall_o, "R1 quiet", {ack_o, stall_o}, 0);
    pre = q.size();
    @(posedge clk); #1 src_apply(p, pb, 0, pre);
  endtask

  task automatic t_regwr(input int a, input logic [7:0] d, input logic p, input logic [7:0] pb);
    int pre;
    @(negedge clk); drive(1, 1, 1, 8'(a), d, p, pb);
    #5;
    chk(ack_o && !stall_o, "R2 write ack", {ack_o, stall_o}, 2);
    pre = q.size();
    @(posedge clk); #1 mreg[a] = d; src_apply(p, pb, 0, pre);
  endtask

  task automatic t_regrd(input int a, input logic p, input logic [7:0] pb);
    int pre;
    logic [7:0] junk;
    junk = 8'($urandom);
    @(negedge clk); drive(1, 1, 0, 8'(a), junk, p, pb);
    #5;
    chk(ack_o && !stall_o, "R2 read ack", {ack_o, stall_o}, 2);
    chk(dat_o == mreg[a], "R2 read data", dat_o, mreg[a]);
    pre = q.size();
    @(posedge clk); #1 src_apply(p, pb, 0, pre);
  endtask

  task automatic t_fwr(input logic [7:0] d, input logic p, input logic [7:0] pb);
    bit expok;
    @(negedge clk); drive(1, 1, 1, FADR, d, p, pb);
    expok = q.size() < DEPTH;
    #5;
    chk(ack_o == expok, "R4 push ack", ack_o, expok);
    chk(!stall_o, "R4 no stall", stall_o, 0);
    @(posedge clk); #1 if (expok) q.push_back(d);
    // R8: a strobed bus push blocks the source byte
  endtask

  task automatic t_frd(input logic p1, input logic [7:0] pb1, input logic p2, input logic [7:0] pb2);
    bit expok;
    int pre;
    logic [7:0] junk, head;
    junk = 8'($urandom);
    @(negedge clk); drive(1, 1, 0, FADR, junk, p1, pb1);
    #5;
    chk(stall_o && !ack_o, "R5 stall cycle", {stall_o, ack_o}, 2);
    expok = q.size() > 0;
    pre = q.size();
    @(posedge clk); #1 src_apply(p1, pb1, 0, pre);
    @(negedge clk); drive(1, 1, 0, FADR, junk, p2, pb2);
    #5;
    head = (q.size() > 0) ? q[0] : 8'h00;
    chk(!stall_o, "R5 single stall", stall_o, 0);
    chk(ack_o == expok, expok ? "R5 pop ack" : "R6 empty no ack", ack_o, expok);
    if (expok) chk(dat_o == head, "R5 pop data order", dat_o, head);
    else       chk(dat_o == junk, "R6 empty pass-through", dat_o, junk);
    pre = q.size();
    @(posedge clk); #1;
    if (expok) void'(q.pop_front());
    src_apply(p2, pb2, 0, pre);
  endtask

  task automatic t_poll(input logic p, input logic [7:0] pb);
    int pre;
    logic [7:0] e;
    @(negedge clk); drive(1, 0, 0, 8'($urandom), 8'($urandom), p, pb);
    e = exp_poll(q.size());
    #5;
    chk(ack_o && !stall_o, "R3 poll ack", {ack_o, stall_o}, 2);
    chk(dat_o == e, "R3 poll count", dat_o, e);
    pre = q.size();
    @(posedge clk); #1 src_apply(p, pb, 0, pre);
  endtask

  task automatic t_unmap(input logic t, input logic [7:0] a, input logic p, input logic [7:0] pb);
    int pre;
    logic [7:0] d;
    d = 8'($urandom);
    @(negedge clk); drive(1, t, t ? 1'($urandom) : 1'b1, a, d, p, pb);
    #5;
    chk(!ack_o && !stall_o, "R7 unmapped quiet", {ack_o, stall_o}, 0);
    chk(dat_o == d, "R7 unmapped pass-through", dat_o, d);
    pre = q.size();
    @(posedge clk); #1 src_apply(p, pb, 0, pre);
  endtask

  function automatic logic [7:0] rand_unmapped();
    logic [7:0] a;
    do a = 8'($urandom_range(NREG, 255)); while (a == FADR);
    return a;
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NREG; i++) mreg[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9 reset state
    t_poll(0, 0);
    for (int i = 0; i < NREG; i++) t_regrd(i, 0, 0);
    t_frd(0, 0, 0, 0);
    chk(q.size() == 0, "R9 empty after reset", q.size(), 0);

    // R2 directed, R7 unmapped leaves registers alone
    t_regwr(0, 8'hA5, 0, 0);
    t_regwr(3, 8'h3C, 0, 0);
    t_unmap(1, rand_unmapped(), 0, 0);
    t_unmap(0, 8'h01, 0, 0);
    t_regrd(0, 0, 0);
    t_regrd(3, 0, 0);

    // R4 fill past full, R3 poll at full
    for (int i = 0; i <= DEPTH; i++) t_fwr(8'(i + 8'h40), 0, 0);
    t_poll(0, 0);
    // R8 source push into a full FIFO is dropped, even with a pop in the same cycle
    t_frd(1, 8'hEE, 1, 8'hEF);
    t_poll(0, 0);
    // R8 source push blocked by a bus push in the same cycle
    t_fwr(8'h77, 1, 8'h99);
    // R5 drain in order, R6 past empty
    for (int i = 0; i <= DEPTH + 1; i++) t_frd(0, 0, 0, 0);
    t_poll(0, 0);
    // R8 source pushes while idle
    t_idle(8'h12, 1, 8'hC1);
    t_idle(8'h34, 1, 8'hC2);
    t_poll(0, 0);
    t_frd(0, 0, 0, 0);

    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic p;
      logic [7:0] pb;
      p  = ($urandom_range(0, 3) == 0);
      pb = 8'($urandom);
      case ($urandom_range(0, 7))
        0: t_idle(8'($urandom), p, pb);
        1: t_regwr($urandom_range(0, NREG - 1), 8'($urandom), p, pb);
        2: t_regrd($urandom_range(0, NREG - 1), p, pb);
        3, 4: t_fwr(8'($urandom), p, pb);
        5: t_frd(p, pb, ($urandom_range(0, 3) == 0), 8'($urandom));
        6: t_poll(p, pb);
        default: t_unmap($urandom_range(0, 1), rand_unmapped(), p, pb);
      endcase
    end

    @(negedge clk); drive(0, 0, 0, 0, 0, 0, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule